// File: doc/BRIEF.md
# Serial Clock Prescale and Divisor Search

This block turns a pair of frequencies into the two settings of a serial clock generator. One is a main clock frequency, the other a requested serial clock frequency, both in hertz. The generator has a 2-bit prescale selector `P` and a 6-bit divisor `B`. It produces `main / (2 << P) / (2 * (B + 1))`, which is the same as `main / ((4 << P) * (B + 1))`. `B` may only take values from 4 to 63.

The block takes one request at a time, with a start strobe. It divides once to get the coarse ratio `main / want`. It then walks the prescale values upward from 0, one per cycle, and stops at the first value that brings the divisor into range. A request that is faster than the generator can run is held at the fastest legal setting. A request that is slower than it can run is held at the slowest legal setting. A second division then reports the serial clock frequency that the chosen settings actually give. The result appears with a one-cycle done pulse and is held until the next result. A request for zero hertz is rejected with an error flag.

Top module: `bd_baud_search`

## Requirements
- R1: While reset is held and on the first cycle after it, `done_o`, `err_o` and `busy_o` are 0, `presc_o` is 0, `divisor_o` is 4 and `actual_hz_o` is 0.
- R2: For a request with `want_hz_i` > 0, let `base = floor(main_hz_i / want_hz_i)` and `q(P) = floor(base / (4 << P))`. If `q(0)` ≥ 5, the result has `presc_o` equal to the smallest `P` in 0..3 with `q(P)` ≤ 64, and `divisor_o = q(P) - 1`.
- R3: A request that is too fast, meaning `q(0)` < 5 (a zero main clock included), gives `presc_o` = 0 and `divisor_o` = 4.
- R4: A request that is too slow, meaning `q(3)` > 64, gives `presc_o` = 3 and `divisor_o` = 63.
- R5: With each result, `actual_hz_o = floor(main_hz_i / ((4 << presc_o) * (divisor_o + 1)))`, using the main frequency of that request.
- R6: Each accepted request produces exactly one `done_o` pulse, one cycle wide. `busy_o` is high from the cycle after a nonzero request is accepted until the result is posted, and it is low on the `done_o` cycle.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. The result that follows belongs to the request already in progress.
- R8: A request with `want_hz_i` = 0 posts a result on the next cycle with `err_o` = 1, `presc_o` = 0, `divisor_o` = 4 and `actual_hz_o` = 0. The next result from a nonzero request clears `err_o`.
- R9: `presc_o`, `divisor_o`, `actual_hz_o` and `err_o` change only on the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| main_hz_i | input | 32 | Main clock frequency in Hz |
| want_hz_i | input | 32 | Requested serial clock frequency in Hz |
| busy_o | output | 1 | A request is being worked on |
| done_o | output | 1 | One-cycle pulse when a result is posted |
| err_o | output | 1 | Last request asked for 0 Hz |
| presc_o | output | 2 | Chosen prescale selector |
| divisor_o | output | 6 | Chosen divisor (4..63) |
| actual_hz_o | output | 32 | Serial clock frequency the chosen settings give |

## Verification
The bench builds the block with its default parameters: 32-bit frequencies, a 2-bit prescale and a 6-bit divisor. With a 100 MHz main clock, the requests cover every prescale value from 0 to 3, exact fits at both ends of the divisor range, and both clamps. A zero main clock and a second main frequency show that the ratio, not the request alone, drives the choice. The directed tests cover the zero-hertz error and how it is cleared, and a start that arrives mid-search.

// File: rtl/bd_search_pkg.sv
// Shared types for the prescale/divisor search.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bd_search_pkg;

    // Control states of the search sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUOT = 2'd1,
        ST_SCAN = 2'd2,
        ST_RATE = 2'd3
    } state_t;

    // Outcome of testing one prescale value.
    typedef enum logic [1:0] {
        VERD_FAST = 2'd0,
        VERD_FIT  = 2'd1,
        VERD_NEXT = 2'd2
    } verdict_t;

endpackage

// File: rtl/bd_restoring_div.sv
// Unsigned restoring divider, one quotient bit per cycle.
// A go_i pulse loads the operands. fin_o pulses W cycles later and quo_o
// then holds the quotient until the next go_i. Assumes den_i != 0.
// The operands are sampled only on the go_i cycle.
module bd_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         fin_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [W:0]    trial;
    logic          fits;
    logic [W:0]    diff;

    // Shift the next dividend bit into the partial remainder and test it.
    always_comb begin
        trial = {rem_q, quo_o[W-1]};
        fits  = (trial >= {1'b0, den_q});
        diff  = trial - {1'b0, den_q};
    end

    // Iterate the divider and raise fin_o after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            quo_o <= '0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                cnt_q <= CW'(W);
                rem_q <= '0;
                den_q <= den_i;
                quo_o <= num_i;
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
                quo_o <= {quo_o[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) fin_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bd_scan_step.sv
// Purely combinational test of one prescale value.
// It derives q = floor(base / (4 << presc)) and decides whether the request
// is too fast (q below the minimum divisor plus one), fits (q at most 2^DIVISOR_W),
// or needs the next prescale. Assumes base is floor(main / want).
module bd_scan_step
    import bd_search_pkg::*;
#(
    parameter int FREQ_W    = 32,
    parameter int PRESC_W   = 2,
    parameter int DIVISOR_W = 6,
    parameter int BRG_MIN   = 4
) (
    input  logic [FREQ_W-1:0]    base_i,
    input  logic [PRESC_W-1:0]   presc_i,
    output verdict_t             verdict_o,
    output logic [DIVISOR_W-1:0] divisor_o
);
    localparam int Q_MIN = BRG_MIN + 1;
    localparam int Q_MAX = 2 ** DIVISOR_W;

    logic [PRESC_W:0]  shamt;
    logic [FREQ_W-1:0] q;
    logic [FREQ_W-1:0] q_less;

    // Scale the ratio for this prescale and classify it.
    always_comb begin
        shamt  = {1'b0, presc_i} + (PRESC_W + 1)'(2);
        q      = base_i >> shamt;
        q_less = q - FREQ_W'(1);
        if (q < FREQ_W'(Q_MIN)) begin
            verdict_o = VERD_FAST;
            divisor_o = DIVISOR_W'(BRG_MIN);
        end else if (q <= FREQ_W'(Q_MAX)) begin
            verdict_o = VERD_FIT;
            divisor_o = q_less[DIVISOR_W-1:0];
        end else begin
            verdict_o = VERD_NEXT;
            divisor_o = '1;
        end
    end
endmodule

// File: rtl/bd_baud_search.sv
// Top of the prescale/divisor search.
// A start_i taken while idle either posts an error result at once (0 Hz
// request) or runs this sequence: divide main by want, test the prescale
// values 0 upward one per cycle, clamp at either end, divide main by the
// total divide ratio, and post the result with a done_o pulse.
// Assumes main_hz_i and want_hz_i are stable only on the start cycle.
module bd_baud_search
    import bd_search_pkg::*;
#(
    parameter int FREQ_W    = 32,
    parameter int PRESC_W   = 2,
    parameter int DIVISOR_W = 6,
    parameter int BRG_MIN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [FREQ_W-1:0]    main_hz_i,
    input  logic [FREQ_W-1:0]    want_hz_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [PRESC_W-1:0]   presc_o,
    output logic [DIVISOR_W-1:0] divisor_o,
    output logic [FREQ_W-1:0]    actual_hz_o
);
    localparam logic [PRESC_W-1:0]   PRESC_TOP = '1;
    localparam logic [DIVISOR_W-1:0] BRG_TOP   = '1;

    state_t               state_q;
    logic [FREQ_W-1:0]    main_q;
    logic [FREQ_W-1:0]    den_q;
    logic [FREQ_W-1:0]    base_q;
    logic [PRESC_W-1:0]   scan_q;
    logic [PRESC_W-1:0]   pick_p_q;
    logic [DIVISOR_W-1:0] pick_b_q;
    logic                 go_q;
    logic                 div_fin;
    logic [FREQ_W-1:0]    div_quo;
    verdict_t             verdict;
    logic [DIVISOR_W-1:0] step_div;
    logic                 chosen;
    logic [PRESC_W-1:0]   sel_p;
    logic [DIVISOR_W-1:0] sel_b;
    logic [PRESC_W:0]     sel_sh;
    logic [FREQ_W-1:0]    sel_den;

    bd_restoring_div #(.W(FREQ_W)) div_u (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (go_q),
        .num_i (main_q),
        .den_i (den_q),
        .fin_o (div_fin),
        .quo_o (div_quo)
    );

    bd_scan_step #(
        .FREQ_W    (FREQ_W),
        .PRESC_W   (PRESC_W),
        .DIVISOR_W (DIVISOR_W),
        .BRG_MIN   (BRG_MIN)
    ) step_u (
        .base_i    (base_q),
        .presc_i   (scan_q),
        .verdict_o (verdict),
        .divisor_o (step_div)
    );

    // Choose the settings for this scan cycle, including the slow clamp.
    always_comb begin
        chosen = 1'b0;
        sel_p  = scan_q;
        sel_b  = step_div;
        if (verdict != VERD_NEXT) begin
            chosen = 1'b1;
        end else if (scan_q == PRESC_TOP) begin
            chosen = 1'b1;
            sel_b  = BRG_TOP;
        end
        sel_sh  = {1'b0, sel_p} + (PRESC_W + 1)'(2);
        sel_den = ({{(FREQ_W - DIVISOR_W){1'b0}}, sel_b} + FREQ_W'(1)) << sel_sh;
    end

    assign busy_o = (state_q != ST_IDLE);

    // Sequence the request and post the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            main_q      <= '0;
            den_q       <= '0;
            base_q      <= '0;
            scan_q      <= '0;
            pick_p_q    <= '0;
            pick_b_q    <= DIVISOR_W'(BRG_MIN);
            go_q        <= 1'b0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
            presc_o     <= '0;
            divisor_o   <= DIVISOR_W'(BRG_MIN);
            actual_hz_o <= '0;
        end else begin
            go_q   <= 1'b0;
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (want_hz_i == '0) begin
                            done_o      <= 1'b1;
                            err_o       <= 1'b1;
                            presc_o     <= '0;
                            divisor_o   <= DIVISOR_W'(BRG_MIN);
                            actual_hz_o <= '0;
                        end else begin
                            main_q  <= main_hz_i;
                            den_q   <= want_hz_i;
                            go_q    <= 1'b1;
                            state_q <= ST_QUOT;
                        end
                    end
                end
                ST_QUOT: begin
                    if (div_fin) begin
                        base_q  <= div_quo;
                        scan_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (chosen) begin
                        pick_p_q <= sel_p;
                        pick_b_q <= sel_b;
                        den_q    <= sel_den;
                        go_q     <= 1'b1;
                        state_q  <= ST_RATE;
                    end else begin
                        scan_q <= scan_q + PRESC_W'(1);
                    end
                end
                ST_RATE: begin
                    if (div_fin) begin
                        presc_o     <= pick_p_q;
                        divisor_o   <= pick_b_q;
                        actual_hz_o <= div_quo;
                        err_o       <= 1'b0;
                        done_o      <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bd_baud_search_chk.sv
// Property checker for bd_baud_search, attached by the bind below.
// Observes the top-level ports only.
module bd_baud_search_chk #(
    parameter int FREQ_W    = 32,
    parameter int PRESC_W   = 2,
    parameter int DIVISOR_W = 6,
    parameter int BRG_MIN   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [FREQ_W-1:0]    main_hz_i,
    input logic [FREQ_W-1:0]    want_hz_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 err_o,
    input logic [PRESC_W-1:0]   presc_o,
    input logic [DIVISOR_W-1:0] divisor_o,
    input logic [FREQ_W-1:0]    actual_hz_o
);
    // A result pulse lasts a single cycle.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // The idle request path is the only way to get a result without being busy first.
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(busy_o));

    // A start while busy leaves the block busy until its result.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    // Result fields move only together with done.
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(presc_o) && $stable(divisor_o)
                     && $stable(actual_hz_o) && $stable(err_o)));

    // A good result never has a divisor below the legal minimum.
    assert_divisor_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (divisor_o >= DIVISOR_W'(BRG_MIN)));

    // An error result carries the fixed fallback settings.
    assert_error_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (presc_o == '0 && divisor_o == DIVISOR_W'(BRG_MIN)
                               && actual_hz_o == '0));
endmodule

bind bd_baud_search bd_baud_search_chk #(
    .FREQ_W    (FREQ_W),
    .PRESC_W   (PRESC_W),
    .DIVISOR_W (DIVISOR_W),
    .BRG_MIN   (BRG_MIN)
) chk_i (.*);

// File: tb/bd_baud_search_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module bd_baud_search_tb_top;

    localparam int FREQ_W = 32;

    typedef struct packed {
        logic [31:0] mhz;
        logic [31:0] want;
        logic [1:0]  p;
        logic [5:0]  b;
        logic [31:0] act;
        logic [1:0]  kind;   // 0 fit (R2), 1 fast (R3), 2 slow (R4)
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'd100000000, 32'd5000000,  2'd0, 6'd4,  32'd5000000, 2'd0},
        '{32'd100000000, 32'd10000000, 2'd0, 6'd4,  32'd5000000, 2'd1},
        '{32'd100000000, 32'd1000000,  2'd0, 6'd24, 32'd1000000, 2'd0},
        '{32'd100000000, 32'd390625,   2'd0, 6'd63, 32'd390625,  2'd0},
        '{32'd100000000, 32'd390000,   2'd0, 6'd63, 32'd390625,  2'd0},
        '{32'd100000000, 32'd300000,   2'd1, 6'd40, 32'd304878,  2'd0},
        '{32'd100000000, 32'd200000,   2'd1, 6'd61, 32'd201612,  2'd0},
        '{32'd100000000, 32'd100000,   2'd2, 6'd61, 32'd100806,  2'd0},
        '{32'd100000000, 32'd48828,    2'd3, 6'd63, 32'd48828,   2'd0},
        '{32'd100000000, 32'd48000,    2'd3, 6'd63, 32'd48828,   2'd2},
        '{32'd100000000, 32'd1,        2'd3, 6'd63, 32'd48828,   2'd2},
        '{32'd20000000,  32'd1000000,  2'd0, 6'd4,  32'd1000000, 2'd0},
        '{32'd0,         32'd5,        2'd0, 6'd4,  32'd0,       2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] main_hz_i = '0;
    logic [31:0] want_hz_i = '0;
    logic        busy_o, done_o, err_o;
    logic [1:0]  presc_o;
    logic [5:0]  divisor_o;
    logic [31:0] actual_hz_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    bd_baud_search dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .main_hz_i   (main_hz_i),
        .want_hz_i   (want_hz_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .presc_o     (presc_o),
        .divisor_o   (divisor_o),
        .actual_hz_o (actual_hz_o)
    );

    // Compare one value and log a failure line.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present one request for a single cycle.
    task automatic pulse_start(input logic [31:0] m, input logic [31:0] w);
        @(negedge clk);
        start_i   = 1'b1;
        main_hz_i = m;
        want_hz_i = w;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    // Wait, sampling at negedges, for the done pulse.
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        bit   seen;
        string tag;
        repeat (3) @(negedge clk);
        // R1: values held through reset
        check("R1", "done in reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done", {31'd0, done_o}, 32'd0);
        check("R1", "err", {31'd0, err_o}, 32'd0);
        check("R1", "busy", {31'd0, busy_o}, 32'd0);
        check("R1", "presc", {30'd0, presc_o}, 32'd0);
        check("R1", "divisor", {26'd0, divisor_o}, 32'd4);
        check("R1", "actual", actual_hz_o, 32'd0);

        // Table walk covers R2, R3, R4 and R5
        for (int k = 0; k < NV; k++) begin
            tag = (VECS[k].kind == 2'd0) ? "R2" : (VECS[k].kind == 2'd1) ? "R3" : "R4";
            pulse_start(VECS[k].mhz, VECS[k].want);
            check("R6", "busy after start", {31'd0, busy_o}, 32'd1);
            wait_done(seen);
            check("R6", "done seen", {31'd0, seen}, 32'd1);
            check(tag, "presc", {30'd0, presc_o}, {30'd0, VECS[k].p});
            check(tag, "divisor", {26'd0, divisor_o}, {26'd0, VECS[k].b});
            check("R5", "actual", actual_hz_o, VECS[k].act);
            check("R5", "actual formula", actual_hz_o,
                  VECS[k].mhz / ((32'd4 << VECS[k].p) * ({26'd0, VECS[k].b} + 32'd1)));
            check("R8", "err clear", {31'd0, err_o}, 32'd0);
            check("R6", "busy low at done", {31'd0, busy_o}, 32'd0);
            @(negedge clk);
            check("R6", "done one cycle", {31'd0, done_o}, 32'd0);
            check("R9", "presc held", {30'd0, presc_o}, {30'd0, VECS[k].p});
        end

        // R8: zero request gives an error result on the next cycle
        pulse_start(32'd100000000, 32'd0);
        check("R8", "done next cycle", {31'd0, done_o}, 32'd1);
        check("R8", "err", {31'd0, err_o}, 32'd1);
        check("R8", "presc", {30'd0, presc_o}, 32'd0);
        check("R8", "divisor", {26'd0, divisor_o}, 32'd4);
        check("R8", "actual", actual_hz_o, 32'd0);
        @(negedge clk);
        check("R9", "err held", {31'd0, err_o}, 32'd1);

        // R7: a second start mid-search is dropped
        pulse_start(32'd100000000, 32'd1000000);
        @(negedge clk);
        start_i = 1'b1; main_hz_i = 32'd100000000; want_hz_i = 32'd300000;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "err held while busy", {31'd0, err_o}, 32'd1);
        wait_done(seen);
        check("R7", "done seen", {31'd0, seen}, 32'd1);
        check("R7", "presc of first", {30'd0, presc_o}, 32'd0);
        check("R7", "divisor of first", {26'd0, divisor_o}, 32'd24);
        check("R7", "actual of first", actual_hz_o, 32'd1000000);
        check("R8", "err cleared", {31'd0, err_o}, 32'd0);
        repeat (100) @(negedge clk);
        check("R7", "no second result", {31'd0, done_o | busy_o}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule